// File: doc/BRIEF.md
# Push-Button Pedestrian Crossing Controller with Vehicle-Gap Gating

This block sequences the vehicle and pedestrian lamps at a push-button road crossing. When vehicles have green and a pedestrian presses the button, the controller records the request. It does not stop the traffic at once. It waits until a road detector has shown no vehicle for five seconds in a row. It then runs a fixed cycle: amber, red with walk, then a flashing phase, and back to green.

All timing comes from a prescaled tick. The number of clocks per tick and the number of ticks per second are parameters, so a bench can shorten every interval. The current phase number (0 to 4) is shown as a decimal digit on one common-cathode seven-segment display.

Top module: `xwalk_ctrl`

## Requirements
- R1: After a synchronous reset the outputs are: vehicle green on, don't-walk on, red, amber and walk off. The display shows digit 0 (seg_out = 7'h3F).
- R2: A button press in phase 0 (vehicle green, idle) is latched. The next phase is 1 (green, waiting for a gap), display 7'h06. The lamps stay green with don't-walk on.
- R3: Phase 1 moves to phase 2 (amber) only after veh_det has been 0 for GAP_SEC seconds of ticks without a break. Any clock with veh_det = 1 (active high: vehicle present) restarts the count from zero. If the gap is already satisfied when the request arrives, amber follows within a few clocks.
- R4: A button press one clock long is never lost while the controller waits for a gap.
- R5: Amber (phase 2, display 7'h5B) lasts AMBER_SEC seconds. Red with walk (phase 3, display 7'h4F) then lasts WALK_SEC seconds.
- R6: The flashing phase (phase 4, display 7'h66) lasts FLASH_SEC seconds. Red and don't-walk are off. Amber and walk blink together at 1 Hz: lit for the first half second, then dark for the next half second. After this phase the controller returns to phase 0.
- R7: Button presses during phases 3 and 4 are discarded. After the return to phase 0 the controller stays in phase 0.
- R8: seg_out is a common-cathode pattern with active-high segments: bit 0 = a, bit 1 = b, up to bit 6 = g.
- R9: Outside phase 4, exactly one vehicle lamp is lit.
- R10: Walk and don't-walk are never lit together. Walk is lit only in phase 3, or in phase 4 while blinking on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ped_btn | input | 1 | Pedestrian request button, active high |
| veh_det | input | 1 | Vehicle detector, 1 = vehicle present |
| lamp_red | output | 1 | Vehicle red lamp |
| lamp_amber | output | 1 | Vehicle amber lamp |
| lamp_green | output | 1 | Vehicle green lamp |
| ped_walk | output | 1 | Pedestrian walk lamp |
| ped_stop | output | 1 | Pedestrian don't-walk lamp |
| seg_out | output | 7 | Seven-segment pattern of the phase number, a in bit 0 |

## Verification
The assertions check the following on every cycle:
- the lamps never conflict, with one vehicle lamp outside flashing and walk excluded from don't-walk;
- the request latch is empty in the walk and flash phases;
- a grant happens only with a full gap count;
- amber ends only after its full dwell.

The bench scenarios show the timing relations, using a behavioural model compared on every clock:
- a detector pulse restarts the five-second wait;
- a one-clock press survives a long wait;
- the amber, walk and flash phases last the required times;
- the 1 Hz blink pattern is correct;
- presses during walk are dropped.

// File: rtl/xwalk_pkg.sv
package xwalk_pkg;

    // Phase numbers are shown on the display, so the encoding is fixed.
    typedef enum logic [2:0] {
        PH_GO      = 3'd0,
        PH_HOLD    = 3'd1,
        PH_CAUTION = 3'd2,
        PH_CROSS   = 3'd3,
        PH_BLINK   = 3'd4
    } phase_e;

endpackage

// File: rtl/xwalk_tick.sv
module xwalk_tick #(
    parameter int CLK_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLK_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(CLK_PER_TICK);
            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                if (pre_q == PW'(CLK_PER_TICK - 1)) pre_d = '0;
                else                                pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) pre_q <= '0;
                else     pre_q <= pre_d;
            end

            assign tick = (pre_q == PW'(CLK_PER_TICK - 1));

            // R3: ticks are isolated single-clock pulses
            a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/xwalk_seg7.sv
module xwalk_seg7 (
    input  logic [3:0] digit,
    output logic [6:0] seg
);
    // R8: common cathode, active high, bit 0 = segment a ... bit 6 = g
    always_comb begin
        unique case (digit)
            4'd0:    seg = 7'h3F;
            4'd1:    seg = 7'h06;
            4'd2:    seg = 7'h5B;
            4'd3:    seg = 7'h4F;
            4'd4:    seg = 7'h66;
            4'd5:    seg = 7'h6D;
            4'd6:    seg = 7'h7D;
            4'd7:    seg = 7'h07;
            4'd8:    seg = 7'h7F;
            4'd9:    seg = 7'h6F;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/xwalk_seq.sv
module xwalk_seq
    import xwalk_pkg::*;
#(
    parameter int GAP_T   = 20,
    parameter int AMBER_T = 12,
    parameter int WALK_T  = 32,
    parameter int FLASH_T = 20,
    parameter int HALF_T  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   ped_btn,
    input  logic   veh_det,
    output phase_e phase,
    output logic   blink_on
);
    localparam int DMAX = (AMBER_T > WALK_T) ? ((AMBER_T > FLASH_T) ? AMBER_T : FLASH_T)
                                             : ((WALK_T > FLASH_T) ? WALK_T : FLASH_T);
    localparam int GW = $clog2(GAP_T + 1);
    localparam int DW = $clog2(DMAX + 1);
    localparam int HW = (HALF_T > 1) ? $clog2(HALF_T) : 1;

    typedef struct packed {
        phase_e        phase;
        logic          req;
        logic [GW-1:0] gap;
        logic [DW-1:0] dwell;
        logic          blink;
        logic [HW-1:0] hcnt;
    } seq_t;

    localparam seq_t SEQ_RST = '{PH_GO, 1'b0, '0, '0, 1'b0, '0};

    seq_t s_d, s_q;
    logic timed;
    logic phase_chg;

    always_comb begin
        s_d = s_q;

        unique case (s_q.phase)
            PH_GO:      if (s_q.req) s_d.phase = PH_HOLD;
            PH_HOLD:    if (s_q.gap == GW'(GAP_T) && !veh_det) s_d.phase = PH_CAUTION;
            PH_CAUTION: if (tick && s_q.dwell == DW'(AMBER_T - 1)) s_d.phase = PH_CROSS;
            PH_CROSS:   if (tick && s_q.dwell == DW'(WALK_T - 1)) s_d.phase = PH_BLINK;
            PH_BLINK:   if (tick && s_q.dwell == DW'(FLASH_T - 1)) s_d.phase = PH_GO;
            default:    s_d.phase = PH_GO;
        endcase

        phase_chg = (s_d.phase != s_q.phase);
        timed     = (s_q.phase == PH_CAUTION) || (s_q.phase == PH_CROSS) ||
                    (s_q.phase == PH_BLINK);

        // request latch: dropped on walk entry and during walk/flash
        if (s_d.phase == PH_CROSS || s_q.phase == PH_CROSS || s_q.phase == PH_BLINK)
            s_d.req = 1'b0;
        else
            s_d.req = s_q.req | ped_btn;

        // vehicle-free interval, saturating at the grant count
        if (veh_det)
            s_d.gap = '0;
        else if (tick && s_q.gap != GW'(GAP_T))
            s_d.gap = s_q.gap + 1'b1;

        // dwell timer for the fixed phases
        if (phase_chg)
            s_d.dwell = '0;
        else if (tick && timed)
            s_d.dwell = s_q.dwell + 1'b1;

        // blink phase: lit on entry, toggles every half second
        if (phase_chg && s_d.phase == PH_BLINK) begin
            s_d.blink = 1'b1;
            s_d.hcnt  = '0;
        end else if (s_q.phase == PH_BLINK && tick) begin
            if (s_q.hcnt == HW'(HALF_T - 1)) begin
                s_d.hcnt  = '0;
                s_d.blink = ~s_q.blink;
            end else begin
                s_d.hcnt = s_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= SEQ_RST;
        else     s_q <= s_d;
    end

    assign phase    = s_q.phase;
    assign blink_on = s_q.blink;

    // R7: no request survives into walk or flash
    a_r7_no_req_in_walk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_CROSS || s_q.phase == PH_BLINK) |-> !s_q.req);

    // R3: the grant happens only with a full gap count
    a_r3_grant_needs_gap: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_CAUTION && $past(s_q.phase) == PH_HOLD) |->
        $past(s_q.gap) == GW'(GAP_T));

    // R5: amber ends only after its full dwell
    a_r5_amber_full: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_CROSS && $past(s_q.phase) == PH_CAUTION) |->
        $past(s_q.dwell) == DW'(AMBER_T - 1));

    // R2: a waiting request only comes from a latched press
    a_r2_hold_from_req: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_HOLD && $past(s_q.phase) == PH_GO) |-> $past(s_q.req));
endmodule

// File: rtl/xwalk_ctrl.sv
module xwalk_ctrl
    import xwalk_pkg::*;
#(
    parameter int CLK_PER_TICK  = 50000,
    parameter int TICKS_PER_SEC = 1000,
    parameter int GAP_SEC       = 5,
    parameter int AMBER_SEC     = 3,
    parameter int WALK_SEC      = 8,
    parameter int FLASH_SEC     = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ped_btn,
    input  logic       veh_det,
    output logic       lamp_red,
    output logic       lamp_amber,
    output logic       lamp_green,
    output logic       ped_walk,
    output logic       ped_stop,
    output logic [6:0] seg_out
);
    localparam int HALF_T = (TICKS_PER_SEC > 1) ? TICKS_PER_SEC / 2 : 1;

    logic   tick;
    phase_e phase;
    logic   blink_on;

    xwalk_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    xwalk_seq #(
        .GAP_T   (GAP_SEC * TICKS_PER_SEC),
        .AMBER_T (AMBER_SEC * TICKS_PER_SEC),
        .WALK_T  (WALK_SEC * TICKS_PER_SEC),
        .FLASH_T (FLASH_SEC * TICKS_PER_SEC),
        .HALF_T  (HALF_T)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ped_btn  (ped_btn),
        .veh_det  (veh_det),
        .phase    (phase),
        .blink_on (blink_on)
    );

    xwalk_seg7 u_seg (
        .digit ({1'b0, phase}),
        .seg   (seg_out)
    );

    always_comb begin
        lamp_red   = 1'b0;
        lamp_amber = 1'b0;
        lamp_green = 1'b0;
        ped_walk   = 1'b0;
        ped_stop   = 1'b0;
        unique case (phase)
            PH_GO, PH_HOLD: begin lamp_green = 1'b1; ped_stop = 1'b1; end
            PH_CAUTION:     begin lamp_amber = 1'b1; ped_stop = 1'b1; end
            PH_CROSS:       begin lamp_red   = 1'b1; ped_walk = 1'b1; end
            PH_BLINK:       begin lamp_amber = blink_on; ped_walk = blink_on; end
            default:        begin lamp_red   = 1'b1; ped_stop = 1'b1; end
        endcase
    end

    // R9: one vehicle lamp outside the flashing phase
    a_r9_one_vehicle_lamp: assert property (@(posedge clk) disable iff (rst)
        (seg_out != 7'h66) |-> $countones({lamp_red, lamp_amber, lamp_green}) == 1);

    // R10: walk never conflicts with don't-walk or with moving traffic
    a_r10_walk_exclusive: assert property (@(posedge clk) disable iff (rst)
        ped_walk |-> (!ped_stop && !lamp_green));
endmodule

// File: tb/xwalk_ctrl_bench.sv
module xwalk_ctrl_bench;
    localparam int CPT   = 2;
    localparam int TPS   = 4;
    localparam int GAP_T = 5 * TPS;
    localparam int AMB_T = 3 * TPS;
    localparam int WLK_T = 8 * TPS;
    localparam int FL_T  = 5 * TPS;
    localparam int HALF  = TPS / 2;

    logic clk = 1'b0, rst = 1'b1, ped = 1'b0, det = 1'b0;
    logic red, amber, green, walk, stop;
    logic [6:0] seg;

    int n_run = 0, n_fail = 0;
    bit done = 0, started = 0;

    // reference model state
    int m_pre, m_st, m_req, m_gap, m_dw, m_bl, m_hc;

    always #2 clk = ~clk;

    xwalk_ctrl #(
        .CLK_PER_TICK(CPT), .TICKS_PER_SEC(TPS),
        .GAP_SEC(5), .AMBER_SEC(3), .WALK_SEC(8), .FLASH_SEC(5)
    ) u_xwalk_ctrl (
        .clk(clk), .rst(rst), .ped_btn(ped), .veh_det(det),
        .lamp_red(red), .lamp_amber(amber), .lamp_green(green),
        .ped_walk(walk), .ped_stop(stop), .seg_out(seg)
    );

    function automatic logic [6:0] pat(int d);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

    always @(posedge clk) begin
        int t, ns, nreq, ngap, ndw, nbl, nhc;
        started = 1;
        if (rst) begin
            m_pre = 0; m_st = 0; m_req = 0; m_gap = 0; m_dw = 0; m_bl = 0; m_hc = 0;
        end else begin
            t  = (m_pre == CPT - 1) ? 1 : 0;
            ns = m_st;
            if (m_st == 0 && m_req != 0) ns = 1;
            else if (m_st == 1 && m_gap == GAP_T && !det) ns = 2;
            else if (m_st == 2 && t == 1 && m_dw == AMB_T - 1) ns = 3;
            else if (m_st == 3 && t == 1 && m_dw == WLK_T - 1) ns = 4;
            else if (m_st == 4 && t == 1 && m_dw == FL_T - 1) ns = 0;
            nreq = (ns == 3 || m_st >= 3) ? 0 : ((m_req != 0 || ped) ? 1 : 0);
            ngap = det ? 0 : ((t == 1 && m_gap < GAP_T) ? m_gap + 1 : m_gap);
            ndw  = (ns != m_st) ? 0 : ((t == 1 && m_st >= 2) ? m_dw + 1 : m_dw);
            nbl = m_bl; nhc = m_hc;
            if (ns == 4 && m_st != 4) begin nbl = 1; nhc = 0; end
            else if (m_st == 4 && t == 1) begin
                if (m_hc == HALF - 1) begin nhc = 0; nbl = 1 - m_bl; end
                else nhc = m_hc + 1;
            end
            m_pre = (t == 1) ? 0 : m_pre + 1;
            m_st = ns; m_req = nreq; m_gap = ngap; m_dw = ndw; m_bl = nbl; m_hc = nhc;
        end
    end

    // every-clock comparison against the model (lamps R9, R10; display R8)
    always @(negedge clk) begin
        logic [11:0] e, a;
        if (started && !done) begin
            e = {m_st == 3, (m_st == 2) || (m_st == 4 && m_bl != 0), m_st <= 1,
                 (m_st == 3) || (m_st == 4 && m_bl != 0), m_st <= 2, pat(m_st)};
            a = {red, amber, green, walk, stop, seg};
            n_run++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL R9 model compare at %0t: actual %h expected %h", $time, a, e);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt, on_seen, off_seen;
        clocks(3);
        rst = 1'b0;
        clocks(1);
        chk("R1 lamps", {red, amber, green, walk, stop}, 5'b00101);
        chk("R1 seg", seg, 7'h3F);

        // R4: one-clock press while traffic present
        det = 1'b1;
        ped = 1'b1; clocks(1); ped = 1'b0;
        clocks(2);
        chk("R2 seg waiting", seg, 7'h06);
        chk("R2 green held", {green, stop}, 2'b11);
        clocks(100);
        chk("R3 vehicles block grant", seg, 7'h06);

        // R3: detector pulse restarts the gap
        det = 1'b0; clocks(30);
        det = 1'b1; clocks(1); det = 1'b0;
        clocks(36);
        chk("R3 gap restarted", seg, 7'h06);
        cnt = 36;
        while (!amber && cnt < 60) begin clocks(1); cnt++; end
        chk("R3 grant after full gap", (cnt >= 39 && cnt <= 43) ? 1 : 0, 1);
        chk("R4 short press served", amber, 1);
        chk("R8 amber digit", seg, 7'h5B);

        // R5 amber dwell
        cnt = 0;
        while (!red && cnt < 60) begin clocks(1); cnt++; end
        chk("R5 amber length", (cnt >= 23 && cnt <= 25) ? 1 : 0, 1);
        chk("R8 walk digit", seg, 7'h4F);
        chk("R10 walk lit alone", {walk, stop}, 2'b10);

        // R7: press during walk is discarded
        ped = 1'b1; clocks(1); ped = 1'b0;
        cnt = 1;
        while (seg != 7'h66 && cnt < 100) begin clocks(1); cnt++; end
        chk("R5 walk length", (cnt >= 63 && cnt <= 65) ? 1 : 0, 1);

        // R6 flashing phase
        chk("R6 blink lit on entry", {red, amber, walk, stop}, 4'b0110);
        ped = 1'b1; clocks(1); ped = 1'b0;
        cnt = 1; on_seen = 0; off_seen = 0;
        while (seg == 7'h66 && cnt < 80) begin
            if (amber) on_seen++; else off_seen++;
            clocks(1); cnt++;
        end
        chk("R6 flash length", (cnt >= 39 && cnt <= 41) ? 1 : 0, 1);
        chk("R6 blink duty", (on_seen >= 19 && on_seen <= 21 && off_seen >= 19) ? 1 : 0, 1);

        // R7: back in phase 0 with no carried request
        chk("R6 returns to green", seg, 7'h3F);
        clocks(20);
        chk("R7 press in walk ignored", seg, 7'h3F);

        // R3 boundary: gap already satisfied
        ped = 1'b1; clocks(1); ped = 1'b0;
        cnt = 1;
        while (!amber && cnt < 20) begin clocks(1); cnt++; end
        chk("R3 immediate grant", (cnt <= 4) ? 1 : 0, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule